// File: doc/BRIEF.md
# Raster Display Timing Generator with Shadowed Timing Registers

This block produces the raster timing for a display: horizontal sync, vertical sync, a data-enable strobe and the current pixel column and line. Software programs the active size, the front and back porches, the sync widths and the sync polarities through a small register port. Each line scans the active pixels, then the front porch, then the sync pulse, then the back porch. The lines of a frame follow the same order.

Every timing register is double-buffered. A write lands in a shadow copy that reads back at once. The timing logic only uses the shadow copy after the frame in progress has ended, and only while the engine is running. A bank of hold bits lets software freeze any single timing register at its current active value across frame boundaries. Each hold bit is addressed by a global index. A one-cycle frame-end pulse marks the start of every new frame. It sets a sticky interrupt status bit, which software can mask and clear.

Top module: `dtg_top`

## Requirements
- R1: With W-1 in bits [CW-1:0] of the size register, each line is W active cycles, then HFP front-porch cycles (bits [CW-1:0] of the horizontal porch word), then HS+1 sync cycles (HS = sync-width register), then HBP back-porch cycles. pix_x counts the cycles from 0 and de is high only in the active part of active lines.
- R2: Lines follow the same order. There are H active lines (H-1 in bits [16+CW-1:16] of the size register), then the vertical front porch, then VS+1 sync lines, then the vertical back porch. The whole of each vsync line is asserted, and pix_y counts the lines.
- R3: Each porch word holds the back porch in bits [16+CW-1:16] and the front porch in bits [CW-1:0]. Bits outside the defined fields are dropped on write and read back as zero.
- R4: The vertical sync width field is 4 bits wide. Any write above 14 stores 14, so a vsync pulse lasts at most 15 lines.
- R5: In the polarity register, bit 0 makes hsync active-low and bit 1 makes vsync active-low. Outside its pulse, each sync sits at its inactive level.
- R6: A timing write reads back at once but changes the outputs only from the first cycle of the next frame.
- R7: While control bit 0 (engine run) is clear, pix_x and pix_y stay 0, de and both syncs are inactive, no frame-end pulse occurs and no shadow value becomes active.
- R8: The timing register with unit number u (h-porch 0, v-porch 1, h-sync 2, v-sync 3, size 4, polarity 5) has its hold bit at global index RLD_BASE+u. That bit lives in hold word index/32 (addresses 9 and up), at bit index mod 32. While the bit is set, the unit keeps its active value.
- R9: While control bit 1 (data gate) is clear, de stays low.
- R10: frame_end is high for exactly one cycle: the first cycle of each frame, where pix_x and pix_y are 0. The shadow copy becomes active on that same edge.
- R11: frame_end sets a sticky status bit, and irq = status AND enable (address 7, bit 0). Reading address 8 returns the masked status. Writing 1 to bit 0 of address 8 clears the status, but a frame end in the same cycle wins.
- R12: After reset, the engine is stopped, all outputs are inactive and 0, the hold words are 0, and the timing registers hold the default timing parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| hsync | output | 1 | Horizontal sync, polarity per register |
| vsync | output | 1 | Vertical sync, polarity per register |
| de | output | 1 | Data enable, high on active pixels |
| pix_x | output | CW+2 | Column counter within the line |
| pix_y | output | CW+2 | Line counter within the frame |
| frame_end | output | 1 | One-cycle pulse on the first cycle of a frame |
| irq | output | 1 | Masked frame-end interrupt |

## Verification
Suppose the active timing copy is corrupted, or is loaded at the wrong moment. The de and sync edges then move within the same line, and the frame length is wrong by the next frame_end. A cycle-accurate comparison therefore catches the fault within a line or a frame. A fault in the hold-bit indexing shows up only one frame after the held register is written, because that is the first frame that should keep the old geometry. Faults in the interrupt status appear on irq or the status read in the cycle after the frame end or the clear.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int unsigned NUM_UNITS = 6;
  localparam int unsigned U_HPORCH  = 0;
  localparam int unsigned U_VPORCH  = 1;
  localparam int unsigned U_HSW     = 2;
  localparam int unsigned U_VSW     = 3;
  localparam int unsigned U_SIZE    = 4;
  localparam int unsigned U_POL     = 5;

  localparam int unsigned A_CTRL    = 6;
  localparam int unsigned A_IRQ_EN  = 7;
  localparam int unsigned A_IRQ_ST  = 8;
  localparam int unsigned A_HOLD0   = 9;

  localparam int unsigned FLD_HI    = 16;
  localparam int unsigned VSW_BITS  = 4;
  localparam logic [31:0] VSW_CAP   = 32'd14;

  localparam int unsigned CTL_RUN   = 0;
  localparam int unsigned CTL_GATE  = 1;
  localparam int unsigned POL_H     = 0;
  localparam int unsigned POL_V     = 1;

  typedef logic [NUM_UNITS-1:0][31:0] unit_words_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int unsigned CW       = 12,
  parameter int unsigned AW       = 4,
  parameter int unsigned RLD_BASE = 30,
  parameter unit_words_t DEF_WORDS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          frame_wrap,
  output unit_words_t   act_words,
  output logic          eng_en,
  output logic          gate_en,
  output logic          irq_en,
  output logic          irq
);
  localparam int unsigned NHW = (RLD_BASE + NUM_UNITS + 31) / 32;

  unit_words_t sh_q, sh_d, act_q, act_d;
  logic [NHW-1:0][31:0] hold_q, hold_d;
  logic run_q, run_d, gate_q, gate_d, ien_q, ien_d, st_q, st_d;
  logic [NUM_UNITS-1:0] held;

  function automatic logic [31:0] fmt_word(input int unsigned u, input logic [31:0] d);
    logic [31:0] r;
    r = '0;
    case (u)
      U_HPORCH, U_VPORCH, U_SIZE: begin
        r[FLD_HI +: CW] = d[FLD_HI +: CW];
        r[CW-1:0]       = d[CW-1:0];
      end
      U_HSW:   r[CW-1:0] = d[CW-1:0];
      U_VSW:   r[VSW_BITS-1:0] = (d > VSW_CAP) ? VSW_CAP[VSW_BITS-1:0] : d[VSW_BITS-1:0];
      default: r[1:0] = d[1:0];
    endcase
    return r;
  endfunction

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_hold
    localparam int unsigned IDX = RLD_BASE + u;
    assign held[u] = hold_q[IDX/32][IDX%32];
  end

  always_comb begin
    sh_d   = sh_q;
    act_d  = act_q;
    hold_d = hold_q;
    run_d  = run_q;
    gate_d = gate_q;
    ien_d  = ien_q;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (frame_wrap && !held[u]) act_d[u] = sh_q[u];
      if (wr_en && wr_addr == AW'(u)) sh_d[u] = fmt_word(u, wr_data);
    end
    for (int k = 0; k < NHW; k++) begin
      if (wr_en && wr_addr == AW'(A_HOLD0 + k)) hold_d[k] = wr_data;
    end
    if (wr_en && wr_addr == AW'(A_CTRL)) begin
      run_d  = wr_data[CTL_RUN];
      gate_d = wr_data[CTL_GATE];
    end
    if (wr_en && wr_addr == AW'(A_IRQ_EN)) ien_d = wr_data[0];
    if (frame_wrap) st_d = 1'b1;
    else if (wr_en && wr_addr == AW'(A_IRQ_ST) && wr_data[0]) st_d = 1'b0;
    else st_d = st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= DEF_WORDS;
      act_q  <= DEF_WORDS;
      hold_q <= '0;
      run_q  <= 1'b0;
      gate_q <= 1'b0;
      ien_q  <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      act_q  <= act_d;
      hold_q <= hold_d;
      run_q  <= run_d;
      gate_q <= gate_d;
      ien_q  <= ien_d;
      st_q   <= st_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (rd_addr == AW'(u)) rd_data = sh_q[u];
    for (int k = 0; k < NHW; k++)
      if (rd_addr == AW'(A_HOLD0 + k)) rd_data = hold_q[k];
    if (rd_addr == AW'(A_CTRL))   rd_data = 32'({gate_q, run_q});
    if (rd_addr == AW'(A_IRQ_EN)) rd_data = 32'(ien_q);
    if (rd_addr == AW'(A_IRQ_ST)) rd_data = 32'(st_q & ien_q);
  end

  assign act_words = act_q;
  assign eng_en    = run_q;
  assign gate_en   = gate_q;
  assign irq_en    = ien_q;
  assign irq       = st_q & ien_q;
endmodule

// File: rtl/dtg_timing.sv
module dtg_timing
  import dtg_pkg::*;
#(
  parameter int unsigned CW  = 12,
  parameter int unsigned CNW = CW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           gate,
  input  unit_words_t    act_words,
  output logic [CNW-1:0] hcnt,
  output logic [CNW-1:0] vcnt,
  output logic           wrap,
  output logic           hs_out,
  output logic           vs_out,
  output logic           de_out
);
  localparam int unsigned PAD = CNW - CW;

  logic [CNW-1:0] h_act, h_fp, h_sw, h_bp, h_sbeg, h_send, h_tot;
  logic [CNW-1:0] v_act, v_fp, v_sw, v_bp, v_sbeg, v_send, v_tot;
  logic [CNW-1:0] hc_q, hc_d, vc_q, vc_d;
  logic last_h, last_v, hs_on, vs_on;
  logic unused_words;

  assign unused_words = ^act_words;

  always_comb begin
    h_act  = {{PAD{1'b0}}, act_words[U_SIZE][CW-1:0]} + 1'b1;
    v_act  = {{PAD{1'b0}}, act_words[U_SIZE][FLD_HI +: CW]} + 1'b1;
    h_fp   = {{PAD{1'b0}}, act_words[U_HPORCH][CW-1:0]};
    h_bp   = {{PAD{1'b0}}, act_words[U_HPORCH][FLD_HI +: CW]};
    v_fp   = {{PAD{1'b0}}, act_words[U_VPORCH][CW-1:0]};
    v_bp   = {{PAD{1'b0}}, act_words[U_VPORCH][FLD_HI +: CW]};
    h_sw   = {{PAD{1'b0}}, act_words[U_HSW][CW-1:0]} + 1'b1;
    v_sw   = {{(CNW-VSW_BITS){1'b0}}, act_words[U_VSW][VSW_BITS-1:0]} + 1'b1;
    h_sbeg = h_act + h_fp;
    h_send = h_sbeg + h_sw;
    h_tot  = h_send + h_bp;
    v_sbeg = v_act + v_fp;
    v_send = v_sbeg + v_sw;
    v_tot  = v_send + v_bp;
  end

  assign last_h = (hc_q == h_tot - 1'b1);
  assign last_v = (vc_q == v_tot - 1'b1);
  assign wrap   = run && last_h && last_v;

  always_comb begin
    hc_d = hc_q;
    vc_d = vc_q;
    if (!run) begin
      hc_d = '0;
      vc_d = '0;
    end else if (last_h) begin
      hc_d = '0;
      vc_d = last_v ? '0 : vc_q + 1'b1;
    end else begin
      hc_d = hc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q <= '0;
      vc_q <= '0;
    end else begin
      hc_q <= hc_d;
      vc_q <= vc_d;
    end
  end

  assign hs_on  = run && (hc_q >= h_sbeg) && (hc_q < h_send);
  assign vs_on  = run && (vc_q >= v_sbeg) && (vc_q < v_send);
  assign hs_out = hs_on ^ act_words[U_POL][POL_H];
  assign vs_out = vs_on ^ act_words[U_POL][POL_V];
  assign de_out = run && gate && (hc_q < h_act) && (vc_q < v_act);
  assign hcnt   = hc_q;
  assign vcnt   = vc_q;
endmodule

// File: rtl/dtg_top.sv
module dtg_top
  import dtg_pkg::*;
#(
  parameter int unsigned CW       = 12,
  parameter int unsigned AW       = 4,
  parameter int unsigned RLD_BASE = 30,
  parameter int unsigned DEF_HACT = 8,
  parameter int unsigned DEF_VACT = 4,
  parameter int unsigned DEF_HFP  = 2,
  parameter int unsigned DEF_HSW  = 2,
  parameter int unsigned DEF_HBP  = 3,
  parameter int unsigned DEF_VFP  = 1,
  parameter int unsigned DEF_VSW  = 2,
  parameter int unsigned DEF_VBP  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [31:0]      rd_data,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [CW+1:0]    pix_x,
  output logic [CW+1:0]    pix_y,
  output logic             frame_end,
  output logic             irq
);
  localparam int unsigned CNW = CW + 2;
  localparam unit_words_t DEF_WORDS = {
    32'd0,
    32'((DEF_VACT - 1) << FLD_HI) | 32'(DEF_HACT - 1),
    32'(DEF_VSW - 1),
    32'(DEF_HSW - 1),
    32'(DEF_VBP << FLD_HI) | 32'(DEF_VFP),
    32'(DEF_HBP << FLD_HI) | 32'(DEF_HFP)
  };

  unit_words_t act_words;
  logic eng_en, gate_en, irq_en, wrap, fe_q;
  logic [CW-1:0] act_wm1;

  dtg_regs #(
    .CW(CW), .AW(AW), .RLD_BASE(RLD_BASE), .DEF_WORDS(DEF_WORDS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_wrap(wrap), .act_words(act_words),
    .eng_en(eng_en), .gate_en(gate_en), .irq_en(irq_en), .irq(irq)
  );

  dtg_timing #(.CW(CW), .CNW(CNW)) u_timing (
    .clk(clk), .rst_n(rst_n), .run(eng_en), .gate(gate_en),
    .act_words(act_words), .hcnt(pix_x), .vcnt(pix_y), .wrap(wrap),
    .hs_out(hsync), .vs_out(vsync), .de_out(de)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fe_q <= 1'b0;
    else        fe_q <= wrap;
  end

  assign frame_end = fe_q;
  assign act_wm1   = act_words[U_SIZE][CW-1:0];
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_end,
  input logic          irq,
  input logic          de,
  input logic [CW+1:0] pix_x,
  input logic [CW+1:0] pix_y,
  input logic          eng_en,
  input logic          gate_en,
  input logic          irq_en,
  input logic [CW-1:0] act_wm1
);
  a_r10_fe_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
  a_r10_fe_origin: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (pix_x == '0 && pix_y == '0));
  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
  a_r11_fe_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && irq_en) |-> irq);
  a_r9_gate_blocks_de: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (gate_en && eng_en));
  a_r1_de_in_width: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (pix_x <= {2'b00, act_wm1}));
  a_r7_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_en && !$past(eng_en)) |-> (pix_x == '0 && pix_y == '0 && !frame_end));
endmodule

bind dtg_top dtg_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .irq(irq), .de(de),
  .pix_x(pix_x), .pix_y(pix_y), .eng_en(eng_en), .gate_en(gate_en),
  .irq_en(irq_en), .act_wm1(act_wm1)
);

// File: tb/tb_dtg_top.sv
`timescale 1ns/1ps
module tb_dtg_top;
  localparam int CW = 12;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic hsync, vsync, de, frame_end, irq;
  logic [CW+1:0] pix_x, pix_y;

  always #2 clk = ~clk;

  dtg_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .frame_end(frame_end), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit chk_on = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_sh[6];
  logic [31:0] m_act[6];
  logic [31:0] m_hold[2];
  bit m_run, m_gate, m_ien, m_st, m_fe;
  int m_hc, m_vc;

  function automatic logic [31:0] m_fmt(int u, logic [31:0] d);
    case (u)
      0, 1, 4: return d & 32'h0FFF_0FFF;
      2:       return d & 32'h0000_0FFF;
      3:       return (d > 32'd14) ? 32'd14 : d;
      default: return d & 32'h3;
    endcase
  endfunction

  task automatic m_reset();
    m_sh[0] = (3 << 16) | 2;  m_sh[1] = (1 << 16) | 1;
    m_sh[2] = 1;              m_sh[3] = 1;
    m_sh[4] = (3 << 16) | 7;  m_sh[5] = 0;
    for (int u = 0; u < 6; u++) m_act[u] = m_sh[u];
    m_hold[0] = 0; m_hold[1] = 0;
    m_run = 0; m_gate = 0; m_ien = 0; m_st = 0; m_fe = 0;
    m_hc = 0; m_vc = 0;
  endtask

  function automatic int fw(int u);  return m_act[u] & 32'hFFF; endfunction
  function automatic int fh(int u);  return (m_act[u] >> 16) & 32'hFFF; endfunction
  function automatic int htot(); return fw(4) + 1 + fw(0) + fw(2) + 1 + fh(0); endfunction
  function automatic int vtot(); return fh(4) + 1 + fw(1) + (m_act[3] & 15) + 1 + fh(1); endfunction

  task automatic m_step();
    bit wrap;
    int ht, vt;
    ht = htot(); vt = vtot();
    wrap = m_run && m_hc == ht - 1 && m_vc == vt - 1;
    if (!m_run) begin m_hc = 0; m_vc = 0; end
    else if (m_hc == ht - 1) begin m_hc = 0; m_vc = (m_vc == vt - 1) ? 0 : m_vc + 1; end
    else m_hc++;
    if (wrap) m_st = 1;
    else if (wr_en && wr_addr == 8 && wr_data[0]) m_st = 0;
    if (wrap)
      for (int u = 0; u < 6; u++) begin
        int idx = 30 + u;
        if (!m_hold[idx / 32][idx % 32]) m_act[u] = m_sh[u];
      end
    if (wr_en) begin
      if (wr_addr < 6) m_sh[wr_addr] = m_fmt(int'(wr_addr), wr_data);
      else if (wr_addr == 6) begin m_run = wr_data[0]; m_gate = wr_data[1]; end
      else if (wr_addr == 7) m_ien = wr_data[0];
      else if (wr_addr == 9) m_hold[0] = wr_data;
      else if (wr_addr == 10) m_hold[1] = wr_data;
    end
    m_fe = wrap;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  function automatic logic [31:0] m_rd(logic [AW-1:0] a);
    if (a < 6) return m_sh[a];
    case (a)
      6: return {30'd0, m_gate, m_run};
      7: return {31'd0, m_ien};
      8: return {31'd0, m_st & m_ien};
      9: return m_hold[0];
      10: return m_hold[1];
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference model
  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      int w, h, hb, he, vb, ve;
      bit e_de, e_hs, e_vs;
      w = fw(4) + 1; h = fh(4) + 1;
      hb = w + fw(0); he = hb + fw(2) + 1;
      vb = h + fw(1); ve = vb + (m_act[3] & 15) + 1;
      e_de = m_run && m_gate && m_hc < w && m_vc < h;
      e_hs = (m_run && m_hc >= hb && m_hc < he) ^ m_act[5][0];
      e_vs = (m_run && m_vc >= vb && m_vc < ve) ^ m_act[5][1];
      chk(pix_x == m_hc, "R1 pix_x", pix_x, m_hc);
      chk(pix_y == m_vc, "R2 pix_y", pix_y, m_vc);
      chk(de == e_de, "R1/R9 de", de, e_de);
      chk(hsync == e_hs, "R1/R5 hsync", hsync, e_hs);
      chk(vsync == e_vs, "R2/R5 vsync", vsync, e_vs);
      chk(frame_end == m_fe, "R10 frame_end", frame_end, m_fe);
      chk(irq == (m_st && m_ien), "R11 irq", irq, m_st && m_ien);
      chk(rd_data == m_rd(rd_addr), "R6 rd_data", rd_data, m_rd(rd_addr));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(posedge clk); #1;
    rd_addr = AW'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic count_frame(output int n);
    do @(negedge clk); while (!frame_end);
    chk(pix_x == 0 && pix_y == 0, "R10 origin at frame_end", pix_x, 0);
    n = 0;
    do begin
      if (de) n++;
      @(negedge clk);
    end while (!frame_end);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_on = 1;
    @(negedge clk);
    // R12 reset state
    chk(!hsync && !vsync && !de && !frame_end && !irq, "R12 outputs idle", {hsync, vsync, de, frame_end, irq}, 0);
    chk(pix_x == 0 && pix_y == 0, "R12 counters zero", pix_x, 0);
    rd(4, d);  chk(d == 32'h0003_0007, "R12 default size", d, 32'h0003_0007);
    rd(10, d); chk(d == 0, "R12 hold word cleared", d, 0);

    // R1 R2: default 8x4 frame
    wr(6, 32'h3);
    count_frame(n); chk(n == 32, "R1 R2 active pixels per frame", n, 32);

    // R11 interrupt
    wr(7, 1);
    do @(negedge clk); while (!frame_end);
    chk(irq == 1, "R11 irq on frame end", irq, 1);
    rd(8, d); chk(d == 1, "R11 masked status", d, 1);
    wr(8, 1);
    @(negedge clk);
    chk(irq == 0, "R11 write-one clear", irq, 0);
    do @(negedge clk); while (!frame_end);
    wr(7, 0);
    rd(8, d); chk(d == 0, "R11 status reads masked", d, 0);
    chk(irq == 0, "R11 irq masked", irq, 0);
    wr(7, 1);
    @(negedge clk); chk(irq == 1, "R11 status sticky under mask", irq, 1);
    wr(8, 1);

    // R3 field layout and masking
    wr(0, 32'hF005_F001);
    rd(0, d); chk(d == 32'h0005_0001, "R3 porch fields masked", d, 32'h0005_0001);
    wr(0, 32'h0001_0001);

    // R6 shadow: new size reads back at once, applies next frame
    wr(4, (2 << 16) | 4);
    rd(4, d); chk(d == 32'h0002_0004, "R6 immediate readback", d, 32'h0002_0004);
    count_frame(n); chk(n == 15, "R6 new size after frame end", n, 15);

    // R4 vertical sync saturation
    wr(3, 20);
    rd(3, d); chk(d == 14, "R4 vsw saturates", d, 14);
    wr(3, 5);
    rd(3, d); chk(d == 5, "R4 vsw in range", d, 5);
    wr(3, 32'h100);
    rd(3, d); chk(d == 14, "R4 vsw large value", d, 14);
    count_frame(n);

    // R5 polarity: at the frame origin both syncs are inactive, hence high
    wr(5, 3);
    do @(negedge clk); while (!frame_end);
    chk(hsync == 1 && vsync == 1, "R5 active-low idle level", {hsync, vsync}, 3);

    // R8 hold bit for size unit: index 34 -> word 1 bit 2
    wr(10, 32'h4);
    wr(4, (1 << 16) | 2);
    count_frame(n); chk(n == 15, "R8 held size unchanged", n, 15);
    count_frame(n); chk(n == 15, "R8 still held", n, 15);
    rd(10, d); chk(d == 4, "R8 hold word readback", d, 4);
    // index 30 -> word 0 bit 30 holds horizontal porch
    wr(9, 32'h4000_0000);
    wr(10, 0);
    wr(0, 32'h0004_0003);
    count_frame(n); chk(n == 6, "R8 released size applies", n, 6);
    wr(9, 0);
    count_frame(n);

    // R9 data gate
    wr(6, 32'h1);
    count_frame(n); chk(n == 0, "R9 gate closed", n, 0);

    // R7 engine stopped
    wr(6, 32'h2);
    wr(4, (3 << 16) | 7);
    n = 0;
    repeat (300) begin
      @(negedge clk);
      if (frame_end || pix_x != 0 || pix_y != 0 || de || hsync != 1'b1) n++;
    end
    chk(n == 0, "R7 stopped engine quiet", n, 0);
    wr(6, 32'h3);
    count_frame(n); chk(n == 32, "R7 no copy while stopped, applies after restart", n, 32);

    repeat (5) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule